// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is the byte exchange point between a host bus and a keyboard controller core. The host writes bytes into an input buffer, either as data or as a command. The core writes bytes into an output buffer for the host to collect. Two flags track the buffers. The input-full flag is set by the host and cleared by the core. The output-full flag is set by the core and cleared by the host.

The host reaches the block through a chip select, read and write strobes, an address bit and an 8-bit data bus. Address 0 selects the data port. Address 1 selects the command port on write and the status byte on read. The core has its own read strobe, write strobe and status-write strobe, an input byte and a view of the input buffer. It is given an interrupt line that follows the input-full flag. The host is given a keyboard interrupt, which is raised when the core loads the output buffer while the enable input is high.

All strobes are synchronous. Each cycle in which a strobe is high counts as one access. The host's read data is combinational and is driven to zero when no host read is in progress.

Top module: `kbc_mailbox`

## Requirements
- R1: After reset, both flags, the command flag, the keyboard interrupt, both buffers and the core-writable status bits are all zero.
- R2: A host write (hcs_i=1, hwr_i=1) loads hdat_i into the input buffer and sets IBF (status bit 1) in the next cycle. Status bit 3 takes the value of ha_i, so it is 1 for a command and 0 for data.
- R3: cdat_o always shows the input buffer. A core read (crd_i=1) clears IBF in the next cycle.
- R4: A core write (cwr_i=1) loads cdat_i into the output buffer and sets OBF (status bit 0) in the next cycle.
- R5: A core write sets kirq_o in the next cycle only when kirq_en_i is 1 in that cycle; otherwise kirq_o stays 0. kirq_o is never high while OBF is clear.
- R6: A host read with ha_i=0 returns the output buffer on hdat_o in the same cycle, and clears OBF and kirq_o in the next cycle.
- R7: A host read with ha_i=1 returns the status byte: bit 0 OBF, bit 1 IBF, bit 3 command flag, and bits 7:4 and 2 from the core. The read has no side effect.
- R8: A host write while IBF is set replaces the input buffer and leaves IBF set.
- R9: When a host write and a core read fall in the same cycle, IBF stays set and the input buffer holds the new byte.
- R10: When a core write and a host data read fall in the same cycle, OBF stays set and the output buffer holds the new byte. The host still reads the old byte in that cycle, and kirq_o follows kirq_en_i.
- R11: A core status write (cstw_i=1) loads bits 7:4 and 2 from cdat_i. It leaves bits 0, 1 and 3 unchanged.
- R12: Host strobes have no effect while hcs_i is 0, and hdat_o reads 0.
- R13: ibf_irq_o equals IBF in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hcs_i | input | 1 | Host chip select |
| hrd_i | input | 1 | Host read strobe |
| hwr_i | input | 1 | Host write strobe |
| ha_i | input | 1 | Host address: 0 data, 1 command/status |
| hdat_i | input | 8 | Host write data |
| hdat_o | output | 8 | Host read data |
| crd_i | input | 1 | Core read of the input buffer |
| cwr_i | input | 1 | Core write of the output buffer |
| cstw_i | input | 1 | Core write of the status bits it owns |
| cdat_i | input | 8 | Core write data |
| cdat_o | output | 8 | Input buffer contents |
| kirq_en_i | input | 1 | Keyboard interrupt enable |
| kirq_o | output | 1 | Keyboard interrupt to the host |
| ibf_irq_o | output | 1 | Input-full interrupt to the core |

## Verification
Each flag has a setter and a clearer on opposite sides, and the two can land in the same cycle. A host write can coincide with a core read, and a core write can coincide with a host data read. The bench drives both strobes of each pair in a single cycle over many byte values. It then checks that the flag remains set, that the buffer holds the new byte, and that the host sees the previous byte during the colliding read. For the output side, the bench also checks that the keyboard interrupt follows the enable seen in the colliding cycle.

// File: rtl/kbc_mailbox_pkg.sv
package kbc_mailbox_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned ST_OBF = 0;
  localparam int unsigned ST_IBF = 1;
  localparam int unsigned ST_CMD = 3;
  localparam logic [DW-1:0] ST_CORE_MASK = 8'hF4;

  typedef struct packed {
    logic ibf;
    logic obf;
    logic cmd;
    logic kirq;
  } mbx_flags_t;

  function automatic logic [DW-1:0] pack_status(input logic [DW-1:0] core_bits,
                                                input mbx_flags_t f);
    logic [DW-1:0] s;
    s = core_bits & ST_CORE_MASK;
    s[ST_OBF] = f.obf;
    s[ST_IBF] = f.ibf;
    s[ST_CMD] = f.cmd;
    return s;
  endfunction
endpackage

// File: rtl/mbx_host_dec.sv
module mbx_host_dec #(
  parameter int unsigned DW = 8
) (
  input  logic          cs_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic          a_i,
  input  logic [DW-1:0] obuf_i,
  input  logic [DW-1:0] status_i,
  output logic          wr_o,
  output logic          rd_data_o,
  output logic [DW-1:0] rdata_o
);
  logic rd_any;

  assign rd_any    = cs_i & rd_i;
  assign wr_o      = cs_i & wr_i;
  assign rd_data_o = rd_any & ~a_i;

  always_comb begin
    rdata_o = '0;
    if (rd_any) rdata_o = a_i ? status_i : obuf_i;
  end

  always_comb begin
    if (!cs_i) AST_NO_ACCESS_UNSELECTED: assert (!wr_o && !rd_data_o && rdata_o == '0); // R12
  end
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags
  import kbc_mailbox_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       h_wr_i,
  input  logic       h_a_i,
  input  logic       h_rd_data_i,
  input  logic       c_rd_i,
  input  logic       c_wr_i,
  input  logic       irq_en_i,
  output mbx_flags_t flags_o
);
  mbx_flags_t q;

  // setter wins over clearer in a colliding cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else begin
      if (h_wr_i) begin
        q.ibf <= 1'b1;
        q.cmd <= h_a_i;
      end else if (c_rd_i) begin
        q.ibf <= 1'b0;
      end
      if (c_wr_i) begin
        q.obf  <= 1'b1;
        q.kirq <= irq_en_i;
      end else if (h_rd_data_i) begin
        q.obf  <= 1'b0;
        q.kirq <= 1'b0;
      end
    end
  end

  assign flags_o = q;

  AST_IBF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_wr_i |=> q.ibf && q.cmd == $past(h_a_i)); // R2
  AST_IBF_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_rd_i && !h_wr_i |=> !q.ibf); // R3
  AST_OBF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_wr_i |=> q.obf); // R4
  AST_KIRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_wr_i |=> q.kirq == $past(irq_en_i)); // R5
  AST_KIRQ_NEEDS_OBF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q.kirq |-> q.obf); // R5
  AST_OBF_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_rd_data_i && !c_wr_i |=> !q.obf && !q.kirq); // R6
  AST_IBF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q.ibf && !c_rd_i |=> q.ibf); // R8
endmodule

// File: rtl/mbx_buffers.sv
module mbx_buffers #(
  parameter int unsigned DW = 8,
  parameter logic [DW-1:0] CORE_MASK = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          h_wr_i,
  input  logic [DW-1:0] h_din_i,
  input  logic          c_wr_i,
  input  logic          c_stw_i,
  input  logic [DW-1:0] c_din_i,
  output logic [DW-1:0] ibuf_o,
  output logic [DW-1:0] obuf_o,
  output logic [DW-1:0] core_bits_o
);
  logic [DW-1:0] ibuf_q, obuf_q, core_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ibuf_q <= '0;
      obuf_q <= '0;
    end else begin
      if (h_wr_i) ibuf_q <= h_din_i;
      if (c_wr_i) obuf_q <= c_din_i;
    end
  end

  for (genvar i = 0; i < DW; i++) begin : g_core_bit
    if (CORE_MASK[i]) begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      core_q[i] <= 1'b0;
        else if (c_stw_i) core_q[i] <= c_din_i[i];
      end
    end else begin : g_zero
      assign core_q[i] = 1'b0;
    end
  end

  assign ibuf_o      = ibuf_q;
  assign obuf_o      = obuf_q;
  assign core_bits_o = core_q;

  AST_IBUF_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_wr_i |=> ibuf_q == $past(h_din_i)); // R2
  AST_OBUF_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_wr_i |=> obuf_q == $past(c_din_i)); // R4
  AST_CORE_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_stw_i |=> core_q == ($past(c_din_i) & CORE_MASK)); // R11
endmodule

// File: rtl/kbc_mailbox.sv
module kbc_mailbox
  import kbc_mailbox_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hcs_i,
  input  logic          hrd_i,
  input  logic          hwr_i,
  input  logic          ha_i,
  input  logic [DW-1:0] hdat_i,
  output logic [DW-1:0] hdat_o,
  input  logic          crd_i,
  input  logic          cwr_i,
  input  logic          cstw_i,
  input  logic [DW-1:0] cdat_i,
  output logic [DW-1:0] cdat_o,
  input  logic          kirq_en_i,
  output logic          kirq_o,
  output logic          ibf_irq_o
);
  logic          h_wr, h_rd_data;
  logic [DW-1:0] ibuf, obuf, core_bits, status;
  mbx_flags_t    flags;

  assign status = pack_status(core_bits, flags);

  mbx_host_dec #(.DW(DW)) u_host_dec (
    .cs_i      (hcs_i),
    .rd_i      (hrd_i),
    .wr_i      (hwr_i),
    .a_i       (ha_i),
    .obuf_i    (obuf),
    .status_i  (status),
    .wr_o      (h_wr),
    .rd_data_o (h_rd_data),
    .rdata_o   (hdat_o)
  );

  mbx_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .h_wr_i      (h_wr),
    .h_a_i       (ha_i),
    .h_rd_data_i (h_rd_data),
    .c_rd_i      (crd_i),
    .c_wr_i      (cwr_i),
    .irq_en_i    (kirq_en_i),
    .flags_o     (flags)
  );

  mbx_buffers #(.DW(DW), .CORE_MASK(ST_CORE_MASK)) u_buffers (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .h_wr_i      (h_wr),
    .h_din_i     (hdat_i),
    .c_wr_i      (cwr_i),
    .c_stw_i     (cstw_i),
    .c_din_i     (cdat_i),
    .ibuf_o      (ibuf),
    .obuf_o      (obuf),
    .core_bits_o (core_bits)
  );

  assign cdat_o    = ibuf;
  assign kirq_o    = flags.kirq;
  assign ibf_irq_o = flags.ibf;

  AST_IBF_IRQ_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ibf_irq_o == status[ST_IBF]); // R13
  AST_STATUS_NOSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcs_i && hrd_i && ha_i && !cwr_i && !crd_i && !hwr_i |=> $stable(status[ST_OBF]) && $stable(status[ST_IBF])); // R7
endmodule

// File: tb/kbc_mailbox_tb.sv
module kbc_mailbox_tb;
  logic clk = 0, rst_n = 0;
  logic hcs = 0, hrd = 0, hwr = 0, ha = 0, crd = 0, cwr = 0, cstw = 0, en = 0;
  logic [7:0] hdi = 0, cdi = 0;
  logic [7:0] hdo, cdo;
  logic kirq, ibf_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  kbc_mailbox u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hcs_i(hcs), .hrd_i(hrd), .hwr_i(hwr), .ha_i(ha),
    .hdat_i(hdi), .hdat_o(hdo), .crd_i(crd), .cwr_i(cwr), .cstw_i(cstw),
    .cdat_i(cdi), .cdat_o(cdo), .kirq_en_i(en), .kirq_o(kirq), .ibf_irq_o(ibf_irq)
  );

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    hcs = 0; hrd = 0; hwr = 0; crd = 0; cwr = 0; cstw = 0;
  endtask

  function automatic logic [7:0] st_exp(input logic [7:0] cb, input logic o, input logic i, input logic c);
    logic [7:0] s;
    s = cb & 8'hF4; s[0] = o; s[1] = i; s[3] = c;
    return s;
  endfunction

  task automatic rd_status(output logic [7:0] v);
    hcs = 1; hrd = 1; ha = 1; #1; v = hdo; hcs = 0; hrd = 0;
  endtask

  logic [7:0] cb;

  initial begin
    logic [7:0] s;
    logic [7:0] v;
    #20; rst_n = 1; cyc();
    // R1 reset state
    rd_status(s); chk(s, 8'h00, "R1");
    chk(cdo, 8'h00, "R1"); chk({7'b0, kirq}, 0, "R1");
    hcs = 1; hrd = 1; ha = 0; #1; chk(hdo, 8'h00, "R1"); idle(); cb = 0;

    for (int k = 0; k < 256; k++) begin
      v = 8'(k);
      // R2 host write, command flag from address
      hcs = 1; hwr = 1; ha = v[1]; hdi = v; cyc(); idle();
      rd_status(s); chk(s, st_exp(cb, 0, 1, v[1]), "R2");
      chk({7'b0, ibf_irq}, 1, "R13");
      // R8 overwrite while full
      hcs = 1; hwr = 1; ha = v[1]; hdi = ~v; cyc(); idle();
      chk(cdo, ~v, "R8"); chk({7'b0, ibf_irq}, 1, "R8");
      // R3 core read clears IBF
      chk(cdo, ~v, "R3"); crd = 1; cyc(); idle();
      rd_status(s); chk(s[1], 0, "R3"); chk({7'b0, ibf_irq}, 0, "R13");
      // R4/R5 core write with enable
      en = v[0]; cdi = v ^ 8'h5A; cwr = 1; cyc(); idle(); en = 0;
      rd_status(s); chk(s, st_exp(cb, 1, 0, v[1]), "R4");
      chk({7'b0, kirq}, {7'b0, v[0]}, "R5");
      // R12 unselected strobes
      hrd = 1; hwr = 1; ha = 0; hdi = 8'hEE; #1; chk(hdo, 8'h00, "R12"); cyc(); idle();
      chk({7'b0, ibf_irq}, 0, "R12"); chk({7'b0, kirq}, {7'b0, v[0]}, "R12");
      // R6 host data read
      hcs = 1; hrd = 1; ha = 0; #1; chk(hdo, v ^ 8'h5A, "R6"); cyc(); idle();
      rd_status(s); chk(s[0], 0, "R6"); chk({7'b0, kirq}, 0, "R6");
      // R9 collision host write + core read
      hcs = 1; hwr = 1; ha = 0; hdi = v + 8'd3; crd = 1; cyc(); idle();
      chk({7'b0, ibf_irq}, 1, "R9"); chk(cdo, v + 8'd3, "R9");
      crd = 1; cyc(); idle();
      // R10 collision core write + host data read
      cdi = v; cwr = 1; cyc(); idle();
      cdi = ~v; cwr = 1; en = v[2]; hcs = 1; hrd = 1; ha = 0; #1;
      chk(hdo, v, "R10"); cyc(); idle(); en = 0;
      rd_status(s); chk(s[0], 1, "R10"); chk({7'b0, kirq}, {7'b0, v[2]}, "R10");
      hcs = 1; hrd = 1; ha = 0; #1; chk(hdo, ~v, "R10"); cyc(); idle();
      // R11 core status write, flags untouched
      cdi = v; cstw = 1; cyc(); idle(); cb = v & 8'hF4;
      rd_status(s); chk(s, st_exp(cb, 0, 0, 0), "R11");
      // R7 status read no side effect
      rd_status(s); cyc(); rd_status(v); chk(v, s, "R7");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (150000) @(posedge clk); checks++; errors++; $display("FAIL watchdog: got timeout expected completion"); end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule